// File: doc/BRIEF.md
# Programmable Periodic Rate Generator

This block turns a one-cycle reference enable into a periodic event pulse at a rate picked by a 4-bit rate code. It can also drive a square wave at that rate and produces a once-per-second update tick. The reference enable stands for a fixed tick stream of 2^REF_LOG2 ticks per second; with the default of 16 that is 65536 ticks per second. Every period below is counted in reference ticks, not in clock cycles. The periodic event is meant to set an interrupt flag elsewhere. The square wave is meant for a pin.

A 3-bit time-base code plays two roles. It changes the meaning of rate codes 1 and 2, and its two top values park the divider chain. The control path is a three-state machine:
- `ST_HOLD`: the chain is parked.
- `ST_IDLE`: running with no rate.
- `ST_RUN`: the rate counter is active.

The transitions are:
- *park*: any state goes to `ST_HOLD` when the base code is 6 or 7.
- *release*: `ST_HOLD` goes to `ST_RUN` or `ST_IDLE`, depending on whether the rate code is nonzero.
- *start*: `ST_IDLE` goes to `ST_RUN` on a nonzero rate code.
- *reload*: `ST_RUN` stays in `ST_RUN` at a period boundary and adopts the current codes.
- *stop*: `ST_RUN` goes to `ST_IDLE` at a boundary when the rate code is 0.

A change of code is taken on at the end of the current period, so a period is never cut short.

Top module: `prg_rate_gen`

## Requirements
- R1: While `base_sel` is 6 or 7, the block gives no `periodic_evt`, no `sec_tick` and a low `sqw_out`. It reads low on all three during and after reset.
- R2: With rate code 0 adopted, `periodic_evt` stays low. Writing code 0 while running still lets the current period end with one last event.
- R3: For rate codes 3 to 15, the event period is 2^code reference ticks, which is 8192 Hz down to 2 Hz. The count covers reference ticks only; cycles without `ref_tick` do not count.
- R4: With `base_sel` = 2, rate codes 1 and 2 give periods of 256 and 512 ticks. With any other running base, they give 2 and 4 ticks.
- R5: `periodic_evt` is a one-cycle pulse, one per period. The first event after release or start comes one full period after counting begins.
- R6: With `sqw_en` high, `sqw_out` is low for the first half of each period and high for the second half, so the duty is 50%. It falls in the same cycle that `periodic_evt` rises.
- R7: With `sqw_en` low, `sqw_out` stays low while events keep running.
- R8: `sec_tick` pulses first 2^(REF_LOG2-1) ticks after the chain leaves hold (half a second), and then every 2^REF_LOG2 ticks.
- R9: A change to `rate_sel` or `base_sel` (other than to 6 or 7) made mid-period is adopted at the next boundary. The pending event keeps its old timing, and the next period uses the new setting.
- R10: From `ST_IDLE`, a nonzero rate code is adopted at once, and its first event follows one full period later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle reference enable, 2^REF_LOG2 per second |
| rate_sel | input | 4 | Rate code; 0 = no events |
| base_sel | input | 3 | Time-base code; 2 = slow base, 6 or 7 = hold chain |
| sqw_en | input | 1 | Square-wave output enable |
| periodic_evt | output | 1 | One-cycle periodic event pulse |
| sqw_out | output | 1 | Square wave at the selected rate |
| sec_tick | output | 1 | One-cycle once-per-second update pulse |

## Verification
The properties assume that `ref_tick` is high for at most one cycle per tick and that the shortest period is two ticks. From this they conclude that two events never fall in consecutive cycles. The hold property assumes that `base_sel` stays at 6 or 7 for at least three cycles before silence is required, which covers one event still in flight. The stimulus changes inputs only at falling edges and keeps the time base at a parking value for several cycles between scenarios. It also thins `ref_tick` only by halving its rate, so every tick stays one cycle wide.

// File: rtl/prg_pkg.sv
package prg_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_IDLE = 2'd1,
        ST_RUN  = 2'd2
    } prg_state_e;

    localparam int RATE_W = 4;
    localparam int BASE_W = 3;

    // Base code 2 is the slow time base: codes 1 and 2 stretch to exponents 8 and 9.
    function automatic logic [RATE_W-1:0] rate_exponent(input logic [RATE_W-1:0] code,
                                                        input logic [BASE_W-1:0] base);
        logic [RATE_W-1:0] e;
        e = code;
        if (base == 3'd2 && code == 4'd1) e = 4'd8;
        if (base == 3'd2 && code == 4'd2) e = 4'd9;
        return e;
    endfunction

    function automatic logic base_parks(input logic [BASE_W-1:0] base);
        return base[2:1] == 2'b11;
    endfunction

endpackage

// File: rtl/prg_sec_chain.sv
module prg_sec_chain #(
    parameter int REF_LOG2 = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic ref_tick,
    output logic sec_tick
);
    localparam int CW = REF_LOG2;
    localparam logic [CW-1:0] HALF_START = {1'b1, {(CW-1){1'b0}}};

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= HALF_START;
            sec_tick <= 1'b0;
        end else if (hold) begin
            cnt_q    <= HALF_START;
            sec_tick <= 1'b0;
        end else if (ref_tick) begin
            cnt_q    <= cnt_q + 1'b1;
            sec_tick <= &cnt_q;
        end else begin
            sec_tick <= 1'b0;
        end
    end

endmodule

// File: rtl/prg_rate_fsm.sv
module prg_rate_fsm
    import prg_pkg::*;
#(
    parameter int REF_LOG2 = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [BASE_W-1:0] base_sel,
    output logic              parked,
    output logic              evt,
    output logic              sqw_raw
);
    localparam int CW  = REF_LOG2;
    localparam int EW  = $clog2(REF_LOG2 + 1);
    localparam int OFF = REF_LOG2 - 16;
    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    prg_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [EW-1:0] exp_q, exp_new;
    logic [CW-1:0] last_val, half_val;
    logic          hold_req, code_nz, boundary, half_hit, restart;

    assign hold_req = base_parks(base_sel);
    assign code_nz  = rate_sel != '0;
    assign exp_new  = EW'(rate_exponent(rate_sel, base_sel)) + EW'(OFF);
    assign last_val = (ONE << exp_q) - ONE;
    assign half_val = (ONE << (exp_q - 1'b1)) - ONE;
    assign boundary = (state_q == ST_RUN) && ref_tick && (cnt_q == last_val);
    assign half_hit = (state_q == ST_RUN) && ref_tick && (cnt_q == half_val);
    assign restart  = (state_q != ST_RUN) || boundary;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (hold_req) begin
            state_d = ST_HOLD;
        end else begin
            unique case (state_q)
                ST_HOLD: state_d = code_nz ? ST_RUN : ST_IDLE;
                ST_IDLE: state_d = code_nz ? ST_RUN : ST_IDLE;
                ST_RUN:  state_d = boundary ? (code_nz ? ST_RUN : ST_IDLE) : ST_RUN;
                default: state_d = ST_HOLD;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // counter and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            exp_q   <= EW'(1 + OFF);
            evt     <= 1'b0;
            sqw_raw <= 1'b0;
        end else begin
            evt <= boundary;
            if (state_d != ST_RUN) begin
                cnt_q   <= '0;
                sqw_raw <= 1'b0;
            end else if (restart) begin
                cnt_q   <= '0;
                sqw_raw <= 1'b0;
                exp_q   <= exp_new;
            end else if (ref_tick) begin
                cnt_q <= cnt_q + 1'b1;
                if (half_hit) sqw_raw <= 1'b1;
            end
        end
    end

    assign parked = (state_q == ST_HOLD);

endmodule

// File: rtl/prg_rate_gen.sv
module prg_rate_gen
    import prg_pkg::*;
#(
    parameter int REF_LOG2 = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic [3:0] rate_sel,
    input  logic [2:0] base_sel,
    input  logic       sqw_en,
    output logic       periodic_evt,
    output logic       sqw_out,
    output logic       sec_tick
);
    logic parked;
    logic sqw_raw;

    prg_rate_fsm #(.REF_LOG2(REF_LOG2)) i_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_tick (ref_tick),
        .rate_sel (rate_sel),
        .base_sel (base_sel),
        .parked   (parked),
        .evt      (periodic_evt),
        .sqw_raw  (sqw_raw)
    );

    prg_sec_chain #(.REF_LOG2(REF_LOG2)) i_sec (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (parked),
        .ref_tick (ref_tick),
        .sec_tick (sec_tick)
    );

    assign sqw_out = sqw_raw & sqw_en;

endmodule

// File: rtl/prg_rate_gen_chk.sv
module prg_rate_gen_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_tick,
    input logic [2:0] base_sel,
    input logic       periodic_evt,
    input logic       sqw_out,
    input logic       sec_tick
);
    logic park_in;
    assign park_in = base_sel[2:1] == 2'b11;

    assert_hold_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (park_in && $past(park_in) && $past(park_in, 2)) |-> (!periodic_evt && !sec_tick && !sqw_out));

    assert_evt_needs_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_evt |-> $past(ref_tick));

    assert_evt_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_evt |=> !periodic_evt);

    assert_sqw_low_at_evt_R6: assert property (@(posedge clk) disable iff (!rst_n)
        periodic_evt |-> !sqw_out);

    assert_sec_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> !sec_tick);

    assert_sec_needs_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> $past(ref_tick));

endmodule

bind prg_rate_gen prg_rate_gen_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_tick     (ref_tick),
    .base_sel     (base_sel),
    .periodic_evt (periodic_evt),
    .sqw_out      (sqw_out),
    .sec_tick     (sec_tick)
);

// File: tb/test_prg_rate_gen.sv
`timescale 1ns/1ps
module test_prg_rate_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b1;
    logic       slow = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic [2:0] base_sel = 3'd7;
    logic       sqw_en = 1'b0;
    logic       periodic_evt, sqw_out, sec_tick;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam int NV = 9;
    localparam int VEC_BASE [NV] = '{0, 0, 1, 2, 0, 1, 2, 2, 2};
    localparam int VEC_RATE [NV] = '{3, 4, 6, 9, 1, 2, 1, 2, 7};
    localparam int VEC_PER  [NV] = '{8, 16, 64, 512, 2, 4, 256, 512, 128};

    always #4 clk = ~clk;

    always @(negedge clk) ref_tick <= slow ? ~ref_tick : 1'b1;

    prg_rate_gen i_prg_rate_gen (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rate_sel(rate_sel),
        .base_sel(base_sel), .sqw_en(sqw_en), .periodic_evt(periodic_evt),
        .sqw_out(sqw_out), .sec_tick(sec_tick)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_evt(output int n);
        n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (!periodic_evt && n < 70000);
    endtask

    task automatic wait_sec(output int n);
        n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
        end while (!sec_tick && n < 70000);
    endtask

    task automatic park();
        base_sel = 3'd7; rate_sel = 4'd0;
        repeat (4) @(negedge clk);
    endtask

    // count high samples of the outputs over a window of cycles
    task automatic quiet_window(input int cyc, output int ne, output int ns, output int nq);
        ne = 0; ns = 0; nq = 0;
        for (int i = 0; i < cyc; i++) begin
            @(posedge clk); @(negedge clk);
            ne += int'(periodic_evt); ns += int'(sec_tick); nq += int'(sqw_out);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n, ne, ns, nq;
        repeat (3) @(negedge clk);
        chk("R1 reset evt", int'(periodic_evt), 0);
        chk("R1 reset sqw", int'(sqw_out), 0);
        chk("R1 reset sec", int'(sec_tick), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // vector table: R3 / R4 periods
        for (int v = 0; v < NV; v++) begin
            park();
            base_sel = 3'(VEC_BASE[v]); rate_sel = 4'(VEC_RATE[v]);
            wait_evt(n);
            chk(VEC_RATE[v] >= 3 ? "R3 first period" : "R4 first period", n, VEC_PER[v] + 1);
            wait_evt(n);
            chk(VEC_RATE[v] >= 3 ? "R3 period" : "R4 period", n, VEC_PER[v]);
        end

        // R6 square wave shape, code 3 (period 8)
        park();
        sqw_en = 1'b1; base_sel = 3'd0; rate_sel = 4'd3;
        wait_evt(n);
        chk("R5 first event", n, 9);
        chk("R6 sqw low at event", int'(sqw_out), 0);
        nq = 0;
        for (int i = 0; i < 8; i++) begin
            @(posedge clk); @(negedge clk);
            if (i < 7) nq += int'(sqw_out);
            if (i == 3) chk("R6 sqw high mid period", int'(sqw_out), 1);
            if (i == 2) chk("R6 sqw low first half", int'(sqw_out), 0);
        end
        chk("R6 sqw high count", nq, 4);
        chk("R5 event after period", int'(periodic_evt), 1);

        // R7 disabled square wave
        sqw_en = 1'b0;
        quiet_window(16, ne, ns, nq);
        chk("R7 sqw stays low", nq, 0);
        chk("R7 events continue", ne, 2);

        // R9 rate change mid-period
        park();
        sqw_en = 1'b1; base_sel = 3'd0; rate_sel = 4'd5;
        wait_evt(n);
        n = 0;
        do begin
            @(posedge clk); n++; @(negedge clk);
            if (n == 10) rate_sel = 4'd3;
        end while (!periodic_evt && n < 70000);
        chk("R9 old period kept", n, 32);
        wait_evt(n);
        chk("R9 new period", n, 8);

        // R9 base change mid-period
        park();
        base_sel = 3'd1; rate_sel = 4'd1;
        wait_evt(n);
        base_sel = 3'd2;
        wait_evt(n);
        chk("R9 base old period", n, 2);
        wait_evt(n);
        chk("R9 base new period", n, 256);

        // R2 idle then R10 start
        park();
        base_sel = 3'd0;
        quiet_window(40, ne, ns, nq);
        chk("R2 no events at code 0", ne, 0);
        chk("R2 sqw low at code 0", nq, 0);
        rate_sel = 4'd4;
        wait_evt(n);
        chk("R10 start from idle", n, 17);
        rate_sel = 4'd0;
        wait_evt(n);
        chk("R2 last event on code 0", n, 16);
        quiet_window(40, ne, ns, nq);
        chk("R2 stopped after boundary", ne, 0);

        // R1 hold while running
        rate_sel = 4'd3;
        wait_evt(n);
        base_sel = 3'd6;
        repeat (2) @(negedge clk);
        quiet_window(40, ne, ns, nq);
        chk("R1 hold evt", ne, 0);
        chk("R1 hold sec", ns, 0);
        chk("R1 hold sqw", nq, 0);

        // R3 ticks only: reference at half rate
        park();
        base_sel = 3'd0; rate_sel = 4'd3;
        slow = 1'b1;
        wait_evt(n);
        wait_evt(n);
        chk("R3 thinned reference", n, 16);
        slow = 1'b0;

        // R8 second tick
        park();
        base_sel = 3'd0;
        wait_sec(n);
        chk("R8 first sec tick", n, 32769);
        wait_sec(n);
        chk("R8 sec period", n, 65536);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule